// File: doc/BRIEF.md
# SPD EEPROM Reader over I2C

This block is a bit-level I2C master that fetches the serial presence detect contents of a memory module and judges them. A start pulse makes it confirm that both bus lines are high, then run a random-read transaction. It writes the device address with the write flag, then a byte offset of zero. A repeated START follows, then the device address with the read flag, and a fixed number of bytes is read sequentially into an on-block byte array.

When the last byte has been taken and the bus released with a STOP, the block sums every byte that lies below the checksum slot and compares the low eight bits against the checksum slot. It then checks that the memory-kind byte names SDR or DDR SDRAM. A one-cycle completion pulse reports the outcome as a fault code and a valid flag. The received bytes stay readable through a combinational read port until the next transaction.

The bus pins are open-drain: an output enable high pulls the line low. The block never drives a line high. SCL timing comes from a quarter-period divider of the system clock.

Top module: `spd_reader`

## Requirements
- R1: After reset, done, valid, busy, scl_oe and sda_oe are 0 and fault is 0 (no fault).
- R2: If SCL or SDA is still low at IDLE_TRIES consecutive quarter-period ticks after start, the block finishes with fault 1 (bus busy) and never drives either line.
- R3: The bytes sent are, in order: {dev_addr, 1'b0}, then 8'h00, then a repeated START (no STOP in between), then {dev_addr, 1'b1}.
- R4: NBYTES bytes are read in sequence. Every byte but the last is acknowledged (SDA low in the ninth bit). The last byte gets a not-acknowledge (SDA high) and is followed by exactly one STOP.
- R5: If any of the three address or offset bytes is not acknowledged, the block sends a STOP, releases both lines and finishes with fault 2 (no acknowledge).
- R6: The 8-bit sum of bytes 0 to SUM_AT-1 (default SUM_AT=63) must equal byte SUM_AT. Otherwise the fault is 3 (checksum), and this takes priority over R7.
- R7: Byte KIND_AT (default 2) must be 8'h04 (SDR) or 8'h07 (DDR). Any other value gives fault 4 (bad kind).
- R8: done is high for exactly one cycle per transaction. valid is 1 exactly when fault is 0, and both hold until the next start.
- R9: SDA changes while SCL is high only to form START, repeated START or STOP. With no clock stretching and QTR_DIV of at least 4, consecutive SCL rising edges are 4*QTR_DIV clocks apart.
- R10: rd_data shows the byte received at position rd_addr of the last transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that begins a transaction while idle |
| dev_addr | input | 7 | 7-bit I2C address of the EEPROM |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| rd_addr | input | AW | Index into the received byte array |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| valid | output | 1 | Last transaction produced usable contents |
| fault | output | 3 | 0 none, 1 bus busy, 2 no acknowledge, 3 checksum, 4 bad kind |
| rd_data | output | 8 | Byte at rd_addr |

## Verification
The assertions assume that the reset is held from time zero and that start arrives only while busy is low. They also assume the target changes SDA only while SCL is low, so every SDA edge under a high SCL is a START or STOP that the master itself produced. The bench EEPROM model updates SDA only right after it sees SCL fall. It issues a new start only after the previous completion pulse. It holds SDA low only in the bus-busy case, and only before the start pulse, so the block itself never drives during that stimulus.

// File: rtl/spd_pkg.sv
package spd_pkg;

  typedef enum logic [1:0] {
    C_START   = 2'd0,
    C_RESTART = 2'd1,
    C_STOP    = 2'd2,
    C_BIT     = 2'd3
  } bit_cmd_e;

  typedef enum logic [2:0] {
    F_NONE = 3'd0,
    F_BUSY = 3'd1,
    F_NACK = 3'd2,
    F_SUM  = 3'd3,
    F_KIND = 3'd4
  } fault_e;

  localparam logic [7:0] KIND_SDR = 8'h04;
  localparam logic [7:0] KIND_DDR = 8'h07;

  // Running checksum: modulo-256 addition.
  function automatic logic [7:0] sum_step(input logic [7:0] acc, input logic [7:0] b);
    return acc + b;
  endfunction

  // Verdict on the fetched contents; the checksum is judged first.
  function automatic fault_e judge(input logic [7:0] acc, input logic [7:0] stored,
                                   input logic [7:0] kind);
    if (acc != stored) return F_SUM;
    if (kind != KIND_SDR && kind != KIND_DDR) return F_KIND;
    return F_NONE;
  endfunction

endpackage

// File: rtl/spd_qtick.sv
module spd_qtick #(
  parameter int QTR_DIV = 312
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (QTR_DIV > 1) ? $clog2(QTR_DIV) : 1;

  generate
    if (QTR_DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_count
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else if (cnt == CW'(QTR_DIV - 1)) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == CW'(QTR_DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/spd_bit_phy.sv
module spd_bit_phy
  import spd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     go,
  input  bit_cmd_e cmd,
  input  logic     wbit,
  input  logic     scl_in,
  input  logic     sda_in,
  output logic     scl_lo,
  output logic     sda_lo,
  output logic     active,
  output logic     fin,
  output logic     rbit
);
  bit_cmd_e   cmd_q;
  logic       wbit_q;
  logic [1:0] ph;

  // Simple stretch wait: hold the sampling phase while a target keeps SCL low.
  logic stall, step;
  assign stall = (cmd_q == C_BIT) && (ph == 2'd2) && !scl_in;
  assign step  = active && tick && !stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= C_START;
      wbit_q <= 1'b1;
      ph     <= '0;
      active <= 1'b0;
      fin    <= 1'b0;
      rbit   <= 1'b1;
      scl_lo <= 1'b0;
      sda_lo <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go && !active) begin
        cmd_q  <= cmd;
        wbit_q <= wbit;
        ph     <= '0;
        active <= 1'b1;
      end else if (step) begin
        ph <= ph + 1'b1;
        if (ph == 2'd3) begin
          active <= 1'b0;
          fin    <= 1'b1;
        end
        case (cmd_q)
          C_START: case (ph)
            2'd0: begin sda_lo <= 1'b0; scl_lo <= 1'b0; end
            2'd1: sda_lo <= 1'b1;
            2'd3: scl_lo <= 1'b1;
            default: ;
          endcase
          C_RESTART: case (ph)
            2'd0: sda_lo <= 1'b0;
            2'd1: scl_lo <= 1'b0;
            2'd2: sda_lo <= 1'b1;
            default: scl_lo <= 1'b1;
          endcase
          C_STOP: case (ph)
            2'd0: sda_lo <= 1'b1;
            2'd1: scl_lo <= 1'b0;
            2'd2: sda_lo <= 1'b0;
            default: ;
          endcase
          default: case (ph)
            2'd0: sda_lo <= ~wbit_q;
            2'd1: scl_lo <= 1'b0;
            2'd2: rbit   <= sda_in;
            default: scl_lo <= 1'b1;
          endcase
        endcase
      end
    end
  end

  // R9: during a data bit SDA holds still while SCL is released
  p_sda_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cmd_q == C_BIT && !scl_lo && $past(active && !scl_lo)) |-> $stable(sda_lo));

  // R3: the sequencer only hands over a command when the engine is free
  p_go_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !active);
endmodule

// File: rtl/spd_reader.sv
module spd_reader
  import spd_pkg::*;
#(
  parameter int NBYTES     = 64,
  parameter int SUM_AT     = 63,
  parameter int KIND_AT    = 2,
  parameter int QTR_DIV    = 312,
  parameter int IDLE_TRIES = 16,
  localparam int AW        = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [6:0]    dev_addr,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic [AW-1:0] rd_addr,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          busy,
  output logic          done,
  output logic          valid,
  output logic [2:0]    fault,
  output logic [7:0]    rd_data
);
  localparam int TW = $clog2(IDLE_TRIES + 1);
  localparam logic [AW-1:0] LAST = AW'(NBYTES - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_START, S_TXB, S_TXA, S_RST,
    S_RXB, S_RXA, S_STOP, S_EVAL, S_FIN
  } st_e;

  st_e          st;
  logic         tick, fin, rbit, phy_active;
  logic         go_q, bit_q;
  bit_cmd_e     cmd_q;
  logic [7:0]   sh;
  logic [6:0]   rsh;
  logic [2:0]   bitn;
  logic [1:0]   stage;
  logic [AW-1:0] idx;
  logic [TW-1:0] tries;
  logic [7:0]   acc;
  fault_e       fault_q;
  logic         done_q, valid_q;
  logic [7:0]   mem [NBYTES];

  // Named internal events
  logic       byte_in, lines_idle;
  logic [7:0] byte_val;
  assign byte_in    = (st == S_RXB) && fin && (bitn == 3'd7);
  assign byte_val   = {rsh, rbit};
  assign lines_idle = scl_in && sda_in;

  spd_qtick #(.QTR_DIV(QTR_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  spd_bit_phy u_phy (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go(go_q), .cmd(cmd_q), .wbit(bit_q),
    .scl_in(scl_in), .sda_in(sda_in), .scl_lo(scl_oe), .sda_lo(sda_oe),
    .active(phy_active), .fin(fin), .rbit(rbit)
  );

  always_ff @(posedge clk) begin
    if (byte_in) mem[idx] <= byte_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; go_q <= 1'b0; bit_q <= 1'b1; cmd_q <= C_START;
      sh <= '0; rsh <= '0; bitn <= '0; stage <= '0; idx <= '0; tries <= '0;
      acc <= '0; fault_q <= F_NONE; done_q <= 1'b0; valid_q <= 1'b0;
    end else begin
      go_q   <= 1'b0;
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          valid_q <= 1'b0; fault_q <= F_NONE; tries <= '0; stage <= '0;
          st <= S_CHK;
        end
        S_CHK: if (tick) begin
          if (lines_idle) begin
            go_q <= 1'b1; cmd_q <= C_START; st <= S_START;
          end else if (tries == TW'(IDLE_TRIES - 1)) begin
            fault_q <= F_BUSY; st <= S_FIN;
          end else tries <= tries + 1'b1;
        end
        S_START: if (fin) begin
          sh <= {dev_addr, 1'b0}; bitn <= '0;
          go_q <= 1'b1; cmd_q <= C_BIT; bit_q <= dev_addr[6]; st <= S_TXB;
        end
        S_TXB: if (fin) begin
          go_q <= 1'b1; cmd_q <= C_BIT;
          if (bitn == 3'd7) begin
            bit_q <= 1'b1; st <= S_TXA;
          end else begin
            bitn <= bitn + 1'b1; sh <= sh << 1; bit_q <= sh[6];
          end
        end
        S_TXA: if (fin) begin
          go_q <= 1'b1;
          if (rbit) begin
            fault_q <= F_NACK; cmd_q <= C_STOP; st <= S_STOP;
          end else if (stage == 2'd0) begin
            stage <= 2'd1; sh <= 8'h00; bitn <= '0;
            cmd_q <= C_BIT; bit_q <= 1'b0; st <= S_TXB;
          end else if (stage == 2'd1) begin
            stage <= 2'd2; cmd_q <= C_RESTART; st <= S_RST;
          end else begin
            idx <= '0; bitn <= '0; acc <= '0;
            cmd_q <= C_BIT; bit_q <= 1'b1; st <= S_RXB;
          end
        end
        S_RST: if (fin) begin
          sh <= {dev_addr, 1'b1}; bitn <= '0;
          go_q <= 1'b1; cmd_q <= C_BIT; bit_q <= dev_addr[6]; st <= S_TXB;
        end
        S_RXB: if (fin) begin
          rsh <= byte_val[6:0];
          go_q <= 1'b1; cmd_q <= C_BIT;
          if (bitn == 3'd7) begin
            if (int'(idx) < SUM_AT) acc <= sum_step(acc, byte_val);
            bit_q <= (idx == LAST);
            st <= S_RXA;
          end else begin
            bitn <= bitn + 1'b1; bit_q <= 1'b1;
          end
        end
        S_RXA: if (fin) begin
          go_q <= 1'b1;
          if (idx == LAST) begin
            cmd_q <= C_STOP; st <= S_STOP;
          end else begin
            idx <= idx + 1'b1; bitn <= '0;
            cmd_q <= C_BIT; bit_q <= 1'b1; st <= S_RXB;
          end
        end
        S_STOP: if (fin) st <= (fault_q != F_NONE) ? S_FIN : S_EVAL;
        S_EVAL: begin
          fault_q <= judge(acc, mem[SUM_AT], mem[KIND_AT]);
          st <= S_FIN;
        end
        S_FIN: begin
          done_q <= 1'b1; valid_q <= (fault_q == F_NONE); st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy    = (st != S_IDLE);
  assign done    = done_q;
  assign valid   = valid_q;
  assign fault   = fault_q;
  assign rd_data = mem[rd_addr];

  // R1: idle means both lines are released
  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (!scl_oe && !sda_oe));

  // R2: the bus check never drives a line
  p_check_no_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHK) |-> (!scl_oe && !sda_oe));

  // R5: an aborted transfer has released both lines before it reports
  p_nack_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FIN && fault_q == F_NACK) |-> (!scl_oe && !sda_oe));

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/spd_reader_test.sv
module spd_reader_test;
  localparam int NB = 64;
  localparam int QD = 5;
  localparam int TRIES = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [6:0] dev_addr = 7'h50;
  logic [5:0] rd_addr = '0;
  logic scl_oe, sda_oe, busy, done, valid;
  logic [2:0] fault;
  logic [7:0] rd_data;
  logic slv_sda_lo = 1'b0;
  logic jam = 1'b0;
  wire scl = !scl_oe;
  wire sda = !(sda_oe || slv_sda_lo || jam);

  always #4 clk = ~clk;

  spd_reader #(.NBYTES(NB), .SUM_AT(63), .KIND_AT(2), .QTR_DIV(QD), .IDLE_TRIES(TRIES)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dev_addr(dev_addr),
    .scl_in(scl), .sda_in(sda), .rd_addr(rd_addr),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done),
    .valid(valid), .fault(fault), .rd_data(rd_data));

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- EEPROM model ----------------
  logic [7:0] mem [NB];
  int nack_at = -1;
  logic [7:0] wbytes[$];
  logic mack[$];
  int start_cnt = 0, stop_cnt = 0, hi_chg = 0;
  int cyc = 0, last_rise = 0, scl_per = 0;
  logic pscl = 1'b1, psda = 1'b1;
  int bitc = 0, wcount = 0, ptr = 0;
  logic [7:0] shreg = '0, txbyte = '0;
  bit first = 0, txmode = 0, sending = 0, pend_tx = 0;

  always @(posedge clk) cyc++;

  always @(scl, sda) begin
    if (scl === 1'b1 && pscl === 1'b1 && sda !== psda) begin
      hi_chg++;
      if (sda === 1'b0) begin
        start_cnt++; bitc = 0; first = 1; txmode = 0; sending = 0; pend_tx = 0;
      end else begin
        stop_cnt++; txmode = 0; sending = 0; pend_tx = 0;
      end
    end else if (scl === 1'b1 && pscl === 1'b0) begin
      scl_per = cyc - last_rise; last_rise = cyc;
      if (bitc < 8) begin
        if (!txmode) shreg = {shreg[6:0], sda};
        bitc++;
      end else begin
        if (txmode) begin
          mack.push_back(sda);
          if (sda) sending = 0;
          else begin ptr++; txbyte = mem[ptr % NB]; end
        end else if (pend_tx) begin
          pend_tx = 0; txmode = 1; sending = 1; txbyte = mem[ptr % NB];
        end
        bitc = 0;
      end
    end else if (scl === 1'b0 && pscl === 1'b1) begin
      if (bitc == 8) begin
        if (!txmode) begin
          bit ack;
          wbytes.push_back(shreg);
          ack = (wcount != nack_at) && (!first || shreg[7:1] == 7'h50);
          if (ack && first && shreg[0]) pend_tx = 1;
          if (ack && !first) ptr = shreg;
          first = 0; wcount++;
          slv_sda_lo = ack;
        end else slv_sda_lo = 1'b0;
      end else if (txmode && sending) slv_sda_lo = ~txbyte[7 - bitc];
      else slv_sda_lo = 1'b0;
    end
    pscl = scl; psda = sda;
  end

  int drv_cnt = 0;
  always @(posedge clk) if (scl_oe || sda_oe) drv_cnt++;

  // ---------------- scoreboard ----------------
  int expf_q[$];
  string tag_q[$];

  initial begin : monitor
    forever begin
      @(posedge clk); #1;
      if (done) begin
        if (expf_q.size() == 0) chk(0, "R8 unexpected done", 1, 0);
        else begin
          int ef;
          string tg;
          ef = expf_q.pop_front(); tg = tag_q.pop_front();
          chk(fault == 3'(ef), {tg, " fault"}, fault, ef);
          chk(valid == (ef == 0), "R8 valid at done", valid, ef == 0);
          @(posedge clk); #1;
          chk(!done, "R8 done one cycle", done, 0);
          chk(valid == (ef == 0), "R8 valid held", valid, ef == 0);
        end
      end
    end
  end

  task automatic fill(input int seed, input logic [7:0] kind, input int sum_err);
    logic [7:0] s = '0;
    for (int i = 0; i < 63; i++) mem[i] = 8'(i * seed + 17);
    mem[2] = kind;
    for (int i = 0; i < 63; i++) s = s + mem[i];
    mem[63] = s + 8'(sum_err);
  endtask

  int wb0, mk0, st0, sp0, hc0, dr0;

  task automatic run(input logic [6:0] a, input int ef, input string tg);
    wb0 = wbytes.size(); mk0 = mack.size(); st0 = start_cnt; sp0 = stop_cnt;
    hc0 = hi_chg; dr0 = drv_cnt;
    wcount = 0;
    dev_addr = a;
    expf_q.push_back(ef); tag_q.push_back(tg);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    do begin @(posedge clk); #1; end while (!done);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_good_frames();
    chk(wbytes.size() - wb0 == 3, "R3 bytes written", wbytes.size() - wb0, 3);
    if (wbytes.size() - wb0 == 3) begin
      chk(wbytes[wb0] == 8'hA0, "R3 write address", wbytes[wb0], 8'hA0);
      chk(wbytes[wb0+1] == 8'h00, "R3 offset", wbytes[wb0+1], 0);
      chk(wbytes[wb0+2] == 8'hA1, "R3 read address", wbytes[wb0+2], 8'hA1);
    end
    chk(start_cnt - st0 == 2, "R3 start plus repeated start", start_cnt - st0, 2);
    chk(stop_cnt - sp0 == 1, "R4 single stop", stop_cnt - sp0, 1);
    chk(mack.size() - mk0 == NB, "R4 bytes acked count", mack.size() - mk0, NB);
    if (mack.size() - mk0 == NB) begin
      int acks = 0;
      for (int i = 0; i < NB - 1; i++) if (mack[mk0 + i] == 1'b0) acks++;
      chk(acks == NB - 1, "R4 acks on all but last", acks, NB - 1);
      chk(mack[mk0 + NB - 1] == 1'b1, "R4 nack on last", mack[mk0 + NB - 1], 1);
    end
    chk(hi_chg - hc0 == 3, "R9 sda moves under high scl only for start/stop", hi_chg - hc0, 3);
    chk(scl_per == 4 * QD, "R9 scl period", scl_per, 4 * QD);
    for (int i = 0; i < NB; i++) begin
      @(negedge clk) rd_addr = 6'(i);
      #1 chk(rd_data == mem[i], "R10 stored byte", rd_data, mem[i]);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    #1;
    chk(done == 0 && valid == 0 && busy == 0, "R1 reset flags", {done, valid, busy}, 0);
    chk(fault == 0, "R1 reset fault", fault, 0);
    chk(scl_oe == 0 && sda_oe == 0, "R1 lines released", {scl_oe, sda_oe}, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    fill(3, 8'h07, 0);
    run(7'h50, 0, "R7 DDR kind accepted");
    check_good_frames();

    fill(11, 8'h04, 0);
    run(7'h50, 0, "R7 SDR kind accepted");
    check_good_frames();

    fill(5, 8'h07, 1);
    run(7'h50, 3, "R6 checksum mismatch");

    fill(7, 8'h08, 0);
    run(7'h50, 4, "R7 unknown kind");

    fill(9, 8'h02, 5);
    run(7'h50, 3, "R6 checksum before kind");

    run(7'h51, 2, "R5 address not acked");
    chk(start_cnt - st0 == 1 && stop_cnt - sp0 == 1, "R5 stop after address nack",
        (start_cnt - st0) * 10 + stop_cnt - sp0, 11);
    chk(scl_oe == 0 && sda_oe == 0, "R5 lines released", {scl_oe, sda_oe}, 0);

    nack_at = 1;
    run(7'h50, 2, "R5 offset not acked");
    chk(stop_cnt - sp0 == 1, "R5 stop after offset nack", stop_cnt - sp0, 1);

    nack_at = 2;
    run(7'h50, 2, "R5 read address not acked");
    chk(start_cnt - st0 == 2 && stop_cnt - sp0 == 1, "R5 stop after read address nack",
        (start_cnt - st0) * 10 + stop_cnt - sp0, 21);
    nack_at = -1;

    @(negedge clk) jam = 1'b1;
    repeat (2) @(negedge clk);
    run(7'h50, 1, "R2 bus held busy");
    chk(drv_cnt - dr0 == 0, "R2 no drive while busy", drv_cnt - dr0, 0);
    @(negedge clk) jam = 1'b0;
    repeat (4) @(negedge clk);

    fill(13, 8'h04, 0);
    run(7'h50, 0, "R8 recovery after busy fault");
    check_good_frames();

    repeat (10) @(negedge clk);
    chk(expf_q.size() == 0, "R8 every start completed", expf_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule